// File: doc/BRIEF.md
# Revocable Read-Miss Tracker

This block sits between a load-store unit and the next cache level. It tracks a small number of outstanding read misses, each tagged with the requester's identifier and a program-order sequence number. A read request that hits in the local tag store is answered at once. A read request that misses takes a free tracker slot and is forwarded downstream.

When the core throws away a mispredicted path, it sends a squash carrying a sequence boundary. Every tracked miss that lies after that boundary in program order is revoked in the same cycle. The revocation is forwarded downstream as a per-slot mask, with the same one-cycle latency as a request. A revoked slot stays allocated until the next level answers it. That answer is then discarded: it installs nothing in the tag store and sends nothing back to the load-store unit. A squashed speculative load therefore leaves no trace in the cache.

Responses are matched on both the slot index and the sequence number. A late answer therefore cannot satisfy a newer miss to the same line that was given a fresh slot.

Top module: `spec_miss_unit`

## Requirements
- R1: After reset, `req_ready_o` is high and every valid, cancel and fill output is low. The tag store is empty, so the first request to any line misses.
- R2: An accepted request whose line is present raises `hit_valid_o` with its identifier in the next cycle, and issues no downstream request.
- R3: An accepted request that misses raises `dn_req_valid_o` in the next cycle. The line, the sequence number and the slot index are carried with it. The slot is the lowest-numbered free one.
- R4: While all N slots are occupied, `req_ready_o` is low. A squash is still accepted in that state.
- R5: A squash with boundary B revokes every live, not-yet-revoked slot whose sequence S satisfies (S−B) mod 2^SEQ_W in 1..2^(SEQ_W−1)−1. In the next cycle, bit k of `dn_cancel_o` is set exactly for each revoked slot k. Slots with S equal to B or earlier are untouched. A slot that is already revoked is not signalled again.
- R6: A response to a revoked slot frees the slot, raises no `fill_valid_o` and leaves the tag store unchanged, so the line still misses afterwards.
- R7: A response to a live slot raises `fill_valid_o` in the next cycle, with the slot's identifier and the response data. It frees the slot and installs the line, so a later request to it hits.
- R8: A response whose sequence number differs from the slot's, or whose slot is free, is ignored, and the slot stays occupied.
- R9: A request presented in the same cycle as a squash that it falls after is consumed without a downstream request, a hit reply or a slot.
- R10: A response arriving in the same cycle as a squash that covers its slot is dropped, with no fill and no tag install. No downstream cancel is sent for that slot.
- R11: A new miss to a line whose revoked slot is still pending gets a separate slot. Only the response carrying its own sequence number fills it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | A free slot exists |
| req_line_i | input | LINE_W | Requested line address |
| req_id_i | input | ID_W | Requester identifier |
| req_seq_i | input | SEQ_W | Request sequence number |
| hit_valid_o | output | 1 | Hit reply |
| hit_id_o | output | ID_W | Identifier of the hit |
| squash_valid_i | input | 1 | Squash command |
| squash_seq_i | input | SEQ_W | Last surviving sequence number |
| dn_req_valid_o | output | 1 | Downstream read request |
| dn_req_line_o | output | LINE_W | Downstream line address |
| dn_req_idx_o | output | IDX_W | Slot index of the request |
| dn_req_seq_o | output | SEQ_W | Sequence number of the request |
| dn_cancel_o | output | N | Per-slot downstream cancel mask |
| dn_rsp_valid_i | input | 1 | Downstream response valid |
| dn_rsp_idx_i | input | IDX_W | Slot index being answered |
| dn_rsp_seq_i | input | SEQ_W | Sequence number being answered |
| dn_rsp_data_i | input | DATA_W | Line data |
| fill_valid_o | output | 1 | Fill reply to the load-store unit |
| fill_id_o | output | ID_W | Identifier of the filled request |
| fill_data_o | output | DATA_W | Fill data |

## Verification
The assertions check, on every cycle, the local causality rules:
- a hit never coincides with a downstream request;
- downstream requests, cancel masks and fills each follow an accepted request, a squash or a response;
- a request or response covered by a same-cycle squash produces nothing.

Only the bench scenarios can show the end-to-end properties. These are that a revoked miss leaves the line uninstalled, and that a live miss installs it and later hits. They also cover sequence comparison across wraparound, slot reuse after a stale answer, and backpressure while the tracker is full.

// File: rtl/smu_pkg.sv
package smu_pkg;
  // true when diff (a - b modulo 2^w) places a strictly after b
  function automatic logic seq_after(input logic [31:0] diff, input int unsigned w);
    logic [31:0] m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return ((diff & m) != 32'd0) && !diff[w-1];
  endfunction
endpackage

// File: rtl/smu_tag_store.sv
module smu_tag_store #(
  parameter int LINE_W = 16,
  parameter int SET_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic              rd_hit_o,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = LINE_W - SET_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];

  logic [SET_W-1:0] rd_set, wr_set;
  assign rd_set = rd_line_i[SET_W-1:0];
  assign wr_set = wr_line_i[SET_W-1:0];

  assign rd_hit_o = vld_q[rd_set] && (tag_q[rd_set] == rd_line_i[LINE_W-1:SET_W]);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
      end else if (wr_en_i && (wr_set == SET_W'(s))) begin
        vld_q[s] <= 1'b1;
        tag_q[s] <= wr_line_i[LINE_W-1:SET_W];
      end
    end
  end
endmodule

// File: rtl/smu_miss_table.sv
module smu_miss_table
  import smu_pkg::*;
#(
  parameter int N      = 4,
  parameter int LINE_W = 16,
  parameter int ID_W   = 6,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              full_o,
  output logic [IDX_W-1:0]  free_idx_o,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic [ID_W-1:0]   alloc_id_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  input  logic              squash_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  output logic [N-1:0]      kill_o,
  input  logic              rsp_i,
  input  logic [IDX_W-1:0]  rsp_idx_i,
  input  logic [SEQ_W-1:0]  rsp_seq_i,
  output logic              rsp_live_o,
  output logic [LINE_W-1:0] rsp_line_o,
  output logic [ID_W-1:0]   rsp_id_o
);
  logic [N-1:0]      vld_q, cxl_q, younger, match;
  logic [LINE_W-1:0] line_q [N];
  logic [ID_W-1:0]   id_q   [N];
  logic [SEQ_W-1:0]  seq_q  [N];

  assign full_o = &vld_q;

  always_comb begin
    free_idx_o = '0;
    for (int k = N - 1; k >= 0; k--)
      if (!vld_q[k]) free_idx_o = IDX_W'(k);
  end

  for (genvar k = 0; k < N; k++) begin : g_cmp
    logic [SEQ_W-1:0] diff;
    assign diff       = seq_q[k] - squash_seq_i;
    assign younger[k] = squash_i && seq_after(32'(diff), SEQ_W);
    assign match[k]   = rsp_i && vld_q[k] && (rsp_idx_i == IDX_W'(k)) && (seq_q[k] == rsp_seq_i);
    // a slot answered this cycle is never signalled downstream
    assign kill_o[k]  = vld_q[k] && !cxl_q[k] && younger[k] && !match[k];
  end

  always_comb begin
    rsp_live_o = 1'b0;
    rsp_line_o = '0;
    rsp_id_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (match[k]) begin
        rsp_live_o = !cxl_q[k] && !younger[k];
        rsp_line_o = line_q[k];
        rsp_id_o   = id_q[k];
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_ent
    logic take;
    assign take = alloc_i && (free_idx_o == IDX_W'(k)) && !vld_q[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k]  <= 1'b0;
        cxl_q[k]  <= 1'b0;
        line_q[k] <= '0;
        id_q[k]   <= '0;
        seq_q[k]  <= '0;
      end else if (take) begin
        vld_q[k]  <= 1'b1;
        cxl_q[k]  <= 1'b0;
        line_q[k] <= alloc_line_i;
        id_q[k]   <= alloc_id_i;
        seq_q[k]  <= alloc_seq_i;
      end else if (match[k]) begin
        vld_q[k]  <= 1'b0;
        cxl_q[k]  <= 1'b0;
      end else if (kill_o[k]) begin
        cxl_q[k]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spec_miss_unit.sv
module spec_miss_unit
  import smu_pkg::*;
#(
  parameter int N      = 4,
  parameter int LINE_W = 16,
  parameter int SET_W  = 4,
  parameter int ID_W   = 6,
  parameter int SEQ_W  = 8,
  parameter int DATA_W = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [SEQ_W-1:0]  req_seq_i,
  output logic              hit_valid_o,
  output logic [ID_W-1:0]   hit_id_o,
  input  logic              squash_valid_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  output logic              dn_req_valid_o,
  output logic [LINE_W-1:0] dn_req_line_o,
  output logic [IDX_W-1:0]  dn_req_idx_o,
  output logic [SEQ_W-1:0]  dn_req_seq_o,
  output logic [N-1:0]      dn_cancel_o,
  input  logic              dn_rsp_valid_i,
  input  logic [IDX_W-1:0]  dn_rsp_idx_i,
  input  logic [SEQ_W-1:0]  dn_rsp_seq_i,
  input  logic [DATA_W-1:0] dn_rsp_data_i,
  output logic              fill_valid_o,
  output logic [ID_W-1:0]   fill_id_o,
  output logic [DATA_W-1:0] fill_data_o
);
  logic              full, tag_hit, rsp_live;
  logic [IDX_W-1:0]  free_idx;
  logic [N-1:0]      kill;
  logic [LINE_W-1:0] rsp_line;
  logic [ID_W-1:0]   rsp_id;
  logic [SEQ_W-1:0]  req_diff;
  logic              fire, req_dead, miss_alloc, hit_ok;

  assign req_ready_o = !full;
  assign req_diff    = req_seq_i - squash_seq_i;
  assign fire        = req_valid_i && req_ready_o;
  assign req_dead    = squash_valid_i && seq_after(32'(req_diff), SEQ_W);
  assign miss_alloc  = fire && !tag_hit && !req_dead;
  assign hit_ok      = fire && tag_hit && !req_dead;

  smu_tag_store #(.LINE_W(LINE_W), .SET_W(SET_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_line_i (req_line_i),
    .rd_hit_o  (tag_hit),
    .wr_en_i   (rsp_live),
    .wr_line_i (rsp_line)
  );

  smu_miss_table #(.N(N), .LINE_W(LINE_W), .ID_W(ID_W), .SEQ_W(SEQ_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .full_o       (full),
    .free_idx_o   (free_idx),
    .alloc_i      (miss_alloc),
    .alloc_line_i (req_line_i),
    .alloc_id_i   (req_id_i),
    .alloc_seq_i  (req_seq_i),
    .squash_i     (squash_valid_i),
    .squash_seq_i (squash_seq_i),
    .kill_o       (kill),
    .rsp_i        (dn_rsp_valid_i),
    .rsp_idx_i    (dn_rsp_idx_i),
    .rsp_seq_i    (dn_rsp_seq_i),
    .rsp_live_o   (rsp_live),
    .rsp_line_o   (rsp_line),
    .rsp_id_o     (rsp_id)
  );

  // requests and cancels share one register stage: equal downstream latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_valid_o    <= 1'b0;
      hit_id_o       <= '0;
      dn_req_valid_o <= 1'b0;
      dn_req_line_o  <= '0;
      dn_req_idx_o   <= '0;
      dn_req_seq_o   <= '0;
      dn_cancel_o    <= '0;
      fill_valid_o   <= 1'b0;
      fill_id_o      <= '0;
      fill_data_o    <= '0;
    end else begin
      hit_valid_o    <= hit_ok;
      hit_id_o       <= req_id_i;
      dn_req_valid_o <= miss_alloc;
      dn_req_line_o  <= req_line_i;
      dn_req_idx_o   <= free_idx;
      dn_req_seq_o   <= req_seq_i;
      dn_cancel_o    <= kill;
      fill_valid_o   <= rsp_live;
      fill_id_o      <= rsp_id;
      fill_data_o    <= dn_rsp_data_i;
    end
  end
endmodule

// File: rtl/smu_chk.sv
module smu_chk
  import smu_pkg::*;
#(
  parameter int N      = 4,
  parameter int SEQ_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [SEQ_W-1:0] req_seq_i,
  input logic             hit_valid_o,
  input logic             squash_valid_i,
  input logic [SEQ_W-1:0] squash_seq_i,
  input logic             dn_req_valid_o,
  input logic [N-1:0]     dn_cancel_o,
  input logic             dn_rsp_valid_i,
  input logic [SEQ_W-1:0] dn_rsp_seq_i,
  input logic             fill_valid_o
);
  logic [SEQ_W-1:0] rq_d, rs_d;
  assign rq_d = req_seq_i - squash_seq_i;
  assign rs_d = dn_rsp_seq_i - squash_seq_i;

  // R2
  hit_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> !dn_req_valid_o);

  // R3
  fetch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_valid_o |-> $past(req_valid_i && req_ready_o));

  // R9
  dead_req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && squash_valid_i && seq_after(32'(rq_d), SEQ_W))
      |=> (!dn_req_valid_o && !hit_valid_o));

  // R5
  cancel_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_cancel_o != '0) |-> $past(squash_valid_i));

  // R7
  fill_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> $past(dn_rsp_valid_i));

  // R10
  squashed_rsp_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_rsp_valid_i && squash_valid_i && seq_after(32'(rs_d), SEQ_W)) |=> !fill_valid_o);
endmodule

bind spec_miss_unit smu_chk #(.N(N), .SEQ_W(SEQ_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_seq_i      (req_seq_i),
  .hit_valid_o    (hit_valid_o),
  .squash_valid_i (squash_valid_i),
  .squash_seq_i   (squash_seq_i),
  .dn_req_valid_o (dn_req_valid_o),
  .dn_cancel_o    (dn_cancel_o),
  .dn_rsp_valid_i (dn_rsp_valid_i),
  .dn_rsp_seq_i   (dn_rsp_seq_i),
  .fill_valid_o   (fill_valid_o)
);

// File: tb/tb_spec_miss_unit.sv
`timescale 1ns/1ps
module tb_spec_miss_unit;
  localparam int N = 4, LINE_W = 16, SET_W = 4, ID_W = 6, SEQ_W = 8, DATA_W = 64;
  localparam int IDX_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_ready_o;
  logic [LINE_W-1:0] req_line_i = '0;
  logic [ID_W-1:0] req_id_i = '0;
  logic [SEQ_W-1:0] req_seq_i = '0;
  logic hit_valid_o;
  logic [ID_W-1:0] hit_id_o;
  logic squash_valid_i = 0;
  logic [SEQ_W-1:0] squash_seq_i = '0;
  logic dn_req_valid_o;
  logic [LINE_W-1:0] dn_req_line_o;
  logic [IDX_W-1:0] dn_req_idx_o;
  logic [SEQ_W-1:0] dn_req_seq_o;
  logic [N-1:0] dn_cancel_o;
  logic dn_rsp_valid_i = 0;
  logic [IDX_W-1:0] dn_rsp_idx_i = '0;
  logic [SEQ_W-1:0] dn_rsp_seq_i = '0;
  logic [DATA_W-1:0] dn_rsp_data_i = '0;
  logic fill_valid_o;
  logic [ID_W-1:0] fill_id_o;
  logic [DATA_W-1:0] fill_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  spec_miss_unit dut (.*);

  // {line[32:17], seq[16:9], boundary[8:1], revoked[0]}
  localparam logic [32:0] VEC [6] = '{
    {16'h1230, 8'h10, 8'h0F, 1'b1},
    {16'h4561, 8'h10, 8'h10, 1'b0},
    {16'h7892, 8'h05, 8'h20, 1'b0},
    {16'hABC3, 8'h02, 8'hFE, 1'b1},
    {16'h0DE4, 8'hFE, 8'h02, 1'b0},
    {16'h5555, 8'h90, 8'h11, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0; squash_valid_i = 0; dn_rsp_valid_i = 0;
  endtask

  task automatic put_req(input logic [15:0] l, input logic [5:0] id, input logic [7:0] s);
    req_valid_i = 1; req_line_i = l; req_id_i = id; req_seq_i = s;
  endtask

  task automatic put_sq(input logic [7:0] b);
    squash_valid_i = 1; squash_seq_i = b;
  endtask

  task automatic put_rsp(input logic [1:0] i, input logic [7:0] s, input logic [63:0] d);
    dn_rsp_valid_i = 1; dn_rsp_idx_i = i; dn_rsp_seq_i = s; dn_rsp_data_i = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1
    chk(req_ready_o == 1, "R1 ready", req_ready_o, 1);
    chk({hit_valid_o, dn_req_valid_o, fill_valid_o} == 0 && dn_cancel_o == 0, "R1 outputs idle",
        {hit_valid_o, dn_req_valid_o, fill_valid_o, dn_cancel_o}, 0);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] a; logic [7:0] s, b; logic cx;
      a = VEC[v][32:17]; s = VEC[v][16:9]; b = VEC[v][8:1]; cx = VEC[v][0];
      put_req(a, 6'(v), s); tick();
      chk(dn_req_valid_o && dn_req_line_o == a && dn_req_idx_o == 0 && dn_req_seq_o == s,
          "R3 miss forwarded", {dn_req_valid_o, dn_req_line_o, dn_req_seq_o}, {1'b1, a, s});
      if (v == 0) chk(!hit_valid_o, "R1 empty store misses", hit_valid_o, 0);
      put_sq(b); tick();
      chk(dn_cancel_o == (cx ? 4'b0001 : 4'b0000), "R5 cancel mask", dn_cancel_o, cx);
      put_rsp(0, s, 64'hDA7A_0000 + 64'(v)); tick();
      chk(fill_valid_o == !cx, cx ? "R6 revoked no fill" : "R7 live fill", fill_valid_o, !cx);
      if (!cx) chk(fill_id_o == 6'(v) && fill_data_o == 64'hDA7A_0000 + 64'(v), "R7 fill id/data",
                   fill_data_o, 64'hDA7A_0000 + 64'(v));
      put_req(a, 6'(20 + v), s + 8'd1); tick();
      chk(hit_valid_o == !cx, cx ? "R6 line absent" : "R7 line installed", hit_valid_o, !cx);
      if (!cx) chk(hit_id_o == 6'(20 + v), "R2 hit id", hit_id_o, 20 + v);
      else begin
        chk(dn_req_valid_o && dn_req_idx_o == 0, "R3 refetch slot", dn_req_idx_o, 0);
        put_rsp(0, s + 8'd1, 64'h1); tick();
        chk(fill_valid_o == 1, "R7 refetch fill", fill_valid_o, 1);
      end
    end

    // fill all slots
    for (int k = 0; k < 4; k++) begin
      put_req(16'h0018 + 16'(k), 6'(k + 1), 8'd40 + 8'(k)); tick();
      chk(dn_req_valid_o && dn_req_idx_o == 2'(k), "R3 lowest free slot", dn_req_idx_o, k);
    end
    chk(req_ready_o == 0, "R4 full backpressure", req_ready_o, 0);
    put_sq(8'd41); tick();
    chk(dn_cancel_o == 4'b1100, "R4 R5 squash while full", dn_cancel_o, 4'b1100);
    put_sq(8'd41); tick();
    chk(dn_cancel_o == 4'b0000, "R5 no repeat cancel", dn_cancel_o, 0);
    put_rsp(2, 8'h99, 64'h5); tick();
    chk(fill_valid_o == 0, "R8 stale seq ignored", fill_valid_o, 0);
    chk(req_ready_o == 0, "R8 slot kept", req_ready_o, 0);
    put_rsp(2, 8'd42, 64'h6); tick();
    chk(fill_valid_o == 0, "R6 revoked dropped", fill_valid_o, 0);
    chk(req_ready_o == 1, "R6 slot freed", req_ready_o, 1);
    put_req(16'h001B, 6'd9, 8'd50); tick();
    chk(dn_req_valid_o && dn_req_idx_o == 2, "R11 fresh slot", dn_req_idx_o, 2);
    put_rsp(3, 8'd43, 64'h7); tick();
    chk(fill_valid_o == 0, "R11 stale answer no fill", fill_valid_o, 0);
    put_req(16'h001B, 6'd10, 8'd51); tick();
    chk(!hit_valid_o, "R11 stale answer not installed", hit_valid_o, 0);
    put_rsp(2, 8'd50, 64'hBEEF); tick();
    chk(fill_valid_o && fill_id_o == 9 && fill_data_o == 64'hBEEF, "R11 own answer fills",
        fill_id_o, 9);
    put_rsp(3, 8'd51, 64'h8); tick();
    chk(fill_valid_o && fill_id_o == 10, "R7 second fill", fill_id_o, 10);
    put_req(16'h001B, 6'd11, 8'd52); tick();
    chk(hit_valid_o && hit_id_o == 11, "R7 hit after fill", hit_id_o, 11);
    put_rsp(0, 8'd40, 64'h0); tick();
    chk(fill_valid_o == 1, "R7 older slot fills", fill_valid_o, 1);
    put_rsp(1, 8'd41, 64'h0); tick();
    chk(fill_valid_o == 1, "R5 boundary slot kept", fill_valid_o, 1);

    // same-cycle kill of request
    put_req(16'h0018, 6'd5, 8'd60); put_sq(8'd55); tick();
    chk(!hit_valid_o && !dn_req_valid_o, "R9 killed hit", {hit_valid_o, dn_req_valid_o}, 0);
    put_req(16'h0030, 6'd5, 8'd61); put_sq(8'd55); tick();
    chk(!hit_valid_o && !dn_req_valid_o, "R9 killed miss", {hit_valid_o, dn_req_valid_o}, 0);
    chk(req_ready_o == 1, "R9 no slot taken", req_ready_o, 1);
    put_req(16'h0030, 6'd6, 8'd55); put_sq(8'd55); tick();
    chk(dn_req_valid_o && dn_req_idx_o == 0, "R9 boundary request kept", dn_req_valid_o, 1);
    put_rsp(0, 8'd55, 64'h0); tick();

    // response and squash in the same cycle
    put_req(16'h0047, 6'd7, 8'd70); tick();
    chk(dn_req_valid_o && dn_req_idx_o == 0, "R3 miss slot 0", dn_req_idx_o, 0);
    put_rsp(0, 8'd70, 64'h9); put_sq(8'd65); tick();
    chk(fill_valid_o == 0, "R10 same-cycle drop", fill_valid_o, 0);
    chk(dn_cancel_o == 0, "R10 no cancel for answered slot", dn_cancel_o, 0);
    put_req(16'h0047, 6'd8, 8'd71); tick();
    chk(!hit_valid_o && dn_req_valid_o, "R10 line not installed", hit_valid_o, 0);
    put_rsp(0, 8'd71, 64'h0); tick();

    finish_run();
  end
endmodule